// File: doc/BRIEF.md
# Dual-Rail Ternary Hamming-Distance Search Array

This block is a parallel associative search array. It holds `WORDS` stored words of `BITS` ternary symbols each, one word per column. Each symbol is 0, 1 or don't-care. An incoming binary search word is applied to every column in the same cycle. Each column reports two results: the number of positions where the search word disagrees with its stored word, and a match line that is high when that number is zero.

Internally every search bit is split into a true rail and a complement rail. Every stored symbol is held as a pair of binary weights, one weight per rail. A cell contributes the sum of its two weight-times-rail products. A column's distance is the sum of those contributions over its cells. Clearing both weights gives the don't-care symbol, which never contributes to the distance.

Stored symbols are loaded one cell at a time through a write port that takes a column index, a bit index and a symbol code. Search results are registered and are flagged by a one-cycle valid strobe.

Top module: `dr_tcam_hd`

## Requirements
- R1: Symbol code 2'b00 stores a 0, held as true-rail weight 1 and complement-rail weight 0. Code 2'b01 stores a 1, held as true-rail weight 0 and complement-rail weight 1. Code 2'b10 stores don't-care, held with both weights 0. A cell contributes (true weight AND search bit) plus (complement weight AND inverted search bit).
- R2: The distance of each column equals the number of its non-wildcard positions whose stored value differs from the search bit at the same index. It is output on `$clog2(BITS+1)` bits per column, with column c at bits [c*DW +: DW], and never exceeds `BITS`.
- R3: A don't-care position adds nothing to the distance, whatever the search bit. A word made only of don't-care symbols always reports distance 0.
- R4: Whenever results are valid, a column's match bit is 1 exactly when its reported distance is 0.
- R5: One search word is compared against all columns in the same cycle, and each column reports against its own stored word.
- R6: A search strobed on clock edge t produces results and `res_valid_o` = 1 after edge t. `res_valid_o` is 0 after any edge with no strobe.
- R7: After an edge with no search strobe, the distance and match outputs keep their previous values.
- R8: A write on edge t is seen by a search strobed on edge t+1 or later. A search strobed on the same edge t still sees the old contents.
- R9: A write carrying the reserved code 2'b11 leaves the addressed cell unchanged.
- R10: Reset, which is synchronous and active-low, clears the valid flag, all distances and all match bits, and sets every cell to don't-care. A search issued right after reset therefore matches every column with distance 0.
- R11: A write changes only the one cell named by its column and bit index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for one stored symbol |
| wr_col_i | input | COL_W | Column (stored word) index of the write |
| wr_bit_i | input | BIT_W | Bit position of the write |
| wr_sym_i | input | 2 | Symbol code: 00 zero, 01 one, 10 don't-care, 11 reserved |
| srch_valid_i | input | 1 | Search strobe |
| srch_word_i | input | BITS | Binary search word |
| res_valid_o | output | 1 | Results valid, one cycle per search |
| res_dist_o | output | WORDS*DIST_W | Per-column distance, column c at [c*DIST_W +: DIST_W] |
| res_match_o | output | WORDS | Per-column match line (distance zero) |

## Verification
The bench builds the array with four columns of 3-bit words. At that size every one of the 27 ternary stored words and every one of the 8 search words can be tried exhaustively. The columns are loaded with staggered patterns, so each search also checks that the columns stay independent, and the all-don't-care word is among the patterns. The small index widths also make it practical to test the ordering of a write and a search on the same edge, a reserved-code write, and the holding of outputs between strobes, all directly at the ports.

// File: rtl/dr_tcam_pkg.sv
// Package: shared symbol codes and weight-pair type for the dual-rail
// ternary distance array. Assumes two-bit symbol codes.
package dr_tcam_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO      = 2'b00,
        SYM_ONE       = 2'b01,
        SYM_DONT_CARE = 2'b10,
        SYM_RSVD      = 2'b11
    } sym_e;

    // Weight pair of one cell: one weight per search rail.
    typedef struct packed {
        logic w_true;
        logic w_comp;
    } wpair_t;

    // Map a legal symbol code onto its weight pair (reserved maps to wildcard,
    // but callers never store it).
    function automatic wpair_t sym_to_pair(input logic [1:0] code);
        wpair_t p;
        case (code)
            SYM_ZERO: begin p.w_true = 1'b1; p.w_comp = 1'b0; end
            SYM_ONE:  begin p.w_true = 1'b0; p.w_comp = 1'b1; end
            default:  begin p.w_true = 1'b0; p.w_comp = 1'b0; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/hd_cell.sv
// Module: hd_cell
// One comparison cell. It holds a weight pair and multiplies it with the
// dual-rail search bit. Assumes the rails are complementary, so at most one
// product is nonzero and the sum fits in one bit.
module hd_cell
    import dr_tcam_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [1:0] wr_sym_i,
    input  logic       rail_t_i,
    input  logic       rail_c_i,
    output logic       contrib_o
);

    wpair_t w_q;

    // Weight storage: reset to wildcard, load legal codes, drop the reserved code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else if (wr_en_i && (wr_sym_i != SYM_RSVD)) begin
            w_q <= sym_to_pair(wr_sym_i);
        end
    end

    // Weight-times-rail products, summed (mutually exclusive terms).
    always_comb begin
        contrib_o = (w_q.w_true & rail_t_i) | (w_q.w_comp & rail_c_i);
    end

    // R1
    pair_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(w_q) <= 1);

    // R9
    rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sym_i == SYM_RSVD) |=> $stable(w_q));

    // R11
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(w_q));

endmodule

// File: rtl/hd_column.sv
// Module: hd_column
// One stored word: BITS cells, a population count of their contributions,
// and a separate all-zero detect that forms the match line.
// Assumes the write enables are one-hot or zero across the cells.
module hd_column #(
    parameter int BITS   = 2,
    parameter int DIST_W = $clog2(BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BITS-1:0]   wr_en_i,
    input  logic [1:0]        wr_sym_i,
    input  logic [BITS-1:0]   rail_t_i,
    input  logic [BITS-1:0]   rail_c_i,
    output logic [DIST_W-1:0] dist_o,
    output logic              zero_o
);

    logic [BITS-1:0] contrib;

    for (genvar b = 0; b < BITS; b++) begin : g_cell
        hd_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en_i  (wr_en_i[b]),
            .wr_sym_i (wr_sym_i),
            .rail_t_i (rail_t_i[b]),
            .rail_c_i (rail_c_i[b]),
            .contrib_o(contrib[b])
        );
    end

    // Distance: sum of cell contributions.
    always_comb begin
        dist_o = '0;
        for (int i = 0; i < BITS; i++) begin
            dist_o = dist_o + DIST_W'(contrib[i]);
        end
    end

    // Match line: no cell contributes.
    always_comb begin
        zero_o = ~|contrib;
    end

endmodule

// File: rtl/dr_tcam_hd.sv
// Module: dr_tcam_hd (top)
// Parallel ternary Hamming-distance search array. It expands the search word
// into true/complement rails, decodes single-cell writes, and registers the
// per-column distance and match results. Assumes write indices outside the
// array are simply not decoded.
module dr_tcam_hd #(
    parameter int WORDS  = 4,
    parameter int BITS   = 2,
    localparam int COL_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BIT_W  = (BITS > 1) ? $clog2(BITS) : 1,
    localparam int DIST_W = $clog2(BITS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [COL_W-1:0]        wr_col_i,
    input  logic [BIT_W-1:0]        wr_bit_i,
    input  logic [1:0]              wr_sym_i,
    input  logic                    srch_valid_i,
    input  logic [BITS-1:0]         srch_word_i,
    output logic                    res_valid_o,
    output logic [WORDS*DIST_W-1:0] res_dist_o,
    output logic [WORDS-1:0]        res_match_o
);

    logic [BITS-1:0]         rail_t;
    logic [BITS-1:0]         rail_c;
    logic [WORDS*DIST_W-1:0] col_dist;
    logic [WORDS-1:0]        col_zero;

    // Dual-rail expansion of the search word.
    always_comb begin
        rail_t = srch_word_i;
        rail_c = ~srch_word_i;
    end

    for (genvar c = 0; c < WORDS; c++) begin : g_col
        logic [BITS-1:0] cell_we;

        // Write decode: select the one addressed cell of this column.
        always_comb begin
            for (int b = 0; b < BITS; b++) begin
                cell_we[b] = wr_en_i && (wr_col_i == COL_W'(c)) && (wr_bit_i == BIT_W'(b));
            end
        end

        hd_column #(
            .BITS  (BITS),
            .DIST_W(DIST_W)
        ) u_column (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en_i (cell_we),
            .wr_sym_i(wr_sym_i),
            .rail_t_i(rail_t),
            .rail_c_i(rail_c),
            .dist_o  (col_dist[c*DIST_W +: DIST_W]),
            .zero_o  (col_zero[c])
        );

        // R4
        match_dist_chk: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid_o |-> (res_match_o[c] == (res_dist_o[c*DIST_W +: DIST_W] == '0)));

        // R2
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            res_dist_o[c*DIST_W +: DIST_W] <= DIST_W'(BITS));
    end

    // Result registers: capture on a search strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            res_dist_o  <= '0;
            res_match_o <= '0;
        end else begin
            res_valid_o <= srch_valid_i;
            if (srch_valid_i) begin
                res_dist_o  <= col_dist;
                res_match_o <= col_zero;
            end
        end
    end

    // R6
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_valid_i |=> res_valid_o);

    // R6
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_valid_i |=> !res_valid_o);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_valid_i |=> ($stable(res_dist_o) && $stable(res_match_o)));

endmodule

// File: tb/tb_dr_tcam_hd.sv
`timescale 1ns/1ps
module tb_dr_tcam_hd;
    localparam int WORDS = 4;
    localparam int BITS  = 3;
    localparam int COL_W = 2;
    localparam int BIT_W = 2;
    localparam int DW    = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic [COL_W-1:0]     wr_col = '0;
    logic [BIT_W-1:0]     wr_bit = '0;
    logic [1:0]           wr_sym = '0;
    logic                 srch_valid = 1'b0;
    logic [BITS-1:0]      srch_word = '0;
    logic                 res_valid;
    logic [WORDS*DW-1:0]  res_dist;
    logic [WORDS-1:0]     res_match;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int model [WORDS][BITS];   // 0 = zero, 1 = one, 2 = don't-care

    always #2.5 clk = ~clk;

    dr_tcam_hd #(.WORDS(WORDS), .BITS(BITS)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_col_i(wr_col),
        .wr_bit_i(wr_bit), .wr_sym_i(wr_sym), .srch_valid_i(srch_valid),
        .srch_word_i(srch_word), .res_valid_o(res_valid),
        .res_dist_o(res_dist), .res_match_o(res_match)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_dist(input int c, input logic [BITS-1:0] s);
        int d = 0;
        for (int b = 0; b < BITS; b++)
            if (model[c][b] != 2 && model[c][b] != int'(s[b])) d++;
        return d;
    endfunction

    task automatic do_write(input int c, input int b, input int code);
        @(negedge clk);
        wr_en = 1'b1; wr_col = COL_W'(c); wr_bit = BIT_W'(b); wr_sym = 2'(code);
        @(negedge clk);
        wr_en = 1'b0;
        if (code != 3) model[c][b] = (code == 0) ? 0 : (code == 1) ? 1 : 2;
    endtask

    task automatic check_all(input logic [BITS-1:0] s, input string req);
        for (int c = 0; c < WORDS; c++) begin
            int e = ref_dist(c, s);
            chk(res_dist[c*DW +: DW] == DW'(e), req, int'(res_dist[c*DW +: DW]), e);
            chk(res_match[c] == (e == 0), {req, " match"}, int'(res_match[c]), int'(e == 0));
        end
    endtask

    task automatic do_search(input logic [BITS-1:0] s, input string req);
        @(negedge clk);
        srch_valid = 1'b1; srch_word = s;
        @(negedge clk);
        srch_valid = 1'b0;
        chk(res_valid == 1'b1, "R6 valid", int'(res_valid), 1);
        check_all(s, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        logic [WORDS*DW-1:0] held;
        for (int c = 0; c < WORDS; c++)
            for (int b = 0; b < BITS; b++) model[c][b] = 2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state at the ports
        chk(res_valid == 1'b0, "R10 valid", int'(res_valid), 0);
        chk(res_dist == '0, "R10 dist", int'(res_dist), 0);
        chk(res_match == '0, "R10 match", int'(res_match), 0);
        // R10 / R3 cells start as wildcard: every column matches
        do_search(3'b101, "R10 post-reset search");

        // R1 R2 R3 R5 R11: exhaustive stored words x search words, staggered columns
        for (int k = 0; k < 27; k++) begin
            for (int c = 0; c < WORDS; c++) begin
                int pat = (k + 7 * c) % 27;
                for (int b = 0; b < BITS; b++) begin
                    do_write(c, b, pat % 3);
                    pat = pat / 3;
                end
            end
            for (int s = 0; s < 8; s++) do_search(3'(s), "R2 distance");
        end

        // R7 outputs hold and R6 valid drops after a strobe-free edge
        do_search(3'b010, "R5 parallel");
        held = res_dist;
        @(negedge clk);
        chk(res_valid == 1'b0, "R6 valid drop", int'(res_valid), 0);
        chk(res_dist == held, "R7 hold dist", int'(res_dist), int'(held));

        // R3 all-wildcard word in column 0
        for (int b = 0; b < BITS; b++) do_write(0, b, 2);
        for (int s = 0; s < 8; s++) do_search(3'(s), "R3 wildcard");

        // R8 write and search on the same edge: search sees the old contents
        for (int b = 0; b < BITS; b++) do_write(1, b, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_col = 2'd1; wr_bit = 2'd0; wr_sym = 2'b01;
        srch_valid = 1'b1; srch_word = 3'b001;
        @(negedge clk);
        wr_en = 1'b0; srch_valid = 1'b0;
        chk(res_dist[1*DW +: DW] == 2'd1, "R8 old contents", int'(res_dist[1*DW +: DW]), 1);
        model[1][0] = 1;
        do_search(3'b001, "R8 new contents");

        // R9 reserved code leaves the cell alone
        do_write(2, 1, 1);
        do_write(2, 1, 3);
        do_search(3'b000, "R9 reserved");
        do_search(3'b010, "R9 reserved");

        finish_run();
    end
endmodule